// File: doc/BRIEF.md
# Indirect Channel Configuration Access Window

This block gives a host a two-register window onto a configuration memory that holds one word for each of 256 channels. A command register carries the channel number, a direction bit and a read-only busy flag. A separate holding register carries the data word. When the host writes the command register while the block is idle, a transfer starts. A read brings the addressed word into the holding register. A write stores the current holding register into the addressed word. The busy flag stays set until the transfer has finished.

The memory is shared with a datapath port, and the datapath always wins. A host transfer therefore waits, with busy held high, for as many cycles as the datapath keeps the memory. The controller is a three-state machine:

- **IDLE**: no transfer is in flight, and host writes to either register are accepted.
- **WAIT**: a command is held until the memory is free.
- **FETCH**: the read word is loaded into the holding register.

The transitions are:

- IDLE to WAIT on a command write.
- WAIT to WAIT while the datapath requests the memory.
- WAIT to IDLE when a store is granted.
- WAIT to FETCH when a read is granted.
- FETCH to IDLE unconditionally.

Top module: `cfg_ind_access`

## Requirements
- R1: Command register readback layout: channel number in bits 7:0, direction in bit 14 (1 = read, 0 = write), busy in bit 15, and bits 13:8 always read 0.
- R2: After reset, the command readback and the holding register both read 0.
- R3: A command write while busy is 0 latches the channel and the direction, and busy reads 1 from the next cycle.
- R4: On a read, busy clears on the same clock edge at which the addressed word appears in the holding register. With a free memory, busy lasts two cycles.
- R5: On a write, the holding register value present when the memory is granted is stored into the addressed entry. With a free memory, busy lasts one cycle.
- R6: While the datapath request is 1, it owns the memory, and a pending host transfer stays busy without touching the memory.
- R7: Writes to the command or holding register while busy is 1 have no effect.
- R8: A datapath read returns the addressed word on its read data output in the cycle after the request. A datapath write stores its data in the same cycle as the request.
- R9: Channel codes 00h to FFh address 256 distinct entries. Code 00h is the first entry and code FFh is the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Host write strobe for the command register |
| sel_wdata | input | 16 | Command write data (channel, direction) |
| hold_we | input | 1 | Host write strobe for the holding register |
| hold_wdata | input | 16 | Holding register write data |
| dp_req | input | 1 | Datapath memory request (priority) |
| dp_we | input | 1 | Datapath request is a store |
| dp_addr | input | 8 | Datapath channel index |
| dp_wdata | input | 16 | Datapath store data |
| sel_rd | output | 16 | Command register readback with live busy |
| hold_rd | output | 16 | Holding register readback |
| dp_rdata | output | 16 | Datapath read data, one cycle after request |

## Verification
The bench holds the datapath request across a pending host command. A design that let the host slip through would clear busy early, and the datapath word would then go missing or be corrupted. The bench fires command and holding writes while a transfer is in flight. A design that accepted them would move the channel, or store and return the wrong word. The bench exercises both ends of the channel range, and it writes the holding register in the same cycle as a store command. An off-by-one in the fetch capture would show up as busy clearing one cycle before or after the word lands. Any of these faults makes the holding readback or the later datapath reads disagree with the reference memory.

// File: rtl/cfg_ind_pkg.sv
package cfg_ind_pkg;

    localparam int SEL_W        = 16;
    localparam int SEL_BUSY_BIT = 15;
    localparam int SEL_DIR_BIT  = 14;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FETCH = 2'd2
    } ind_state_t;

endpackage

// File: rtl/cfg_ind_ram.sv
module cfg_ind_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // single port: one store or one fetch per cycle
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/cfg_ind_arb.sv
module cfg_ind_arb #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              dp_req,
    input  logic              dp_we,
    input  logic [ADDR_W-1:0] dp_addr,
    input  logic [DATA_W-1:0] dp_wdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_gnt,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);
    // fixed priority: datapath first, host only in free cycles
    always_comb begin
        host_gnt = host_req && !dp_req;
        if (dp_req) begin
            ram_en    = 1'b1;
            ram_we    = dp_we;
            ram_addr  = dp_addr;
            ram_wdata = dp_wdata;
        end else begin
            ram_en    = host_req;
            ram_we    = host_req && host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end
    end
endmodule

// File: rtl/cfg_ind_ctrl.sv
module cfg_ind_ctrl
    import cfg_ind_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [CH_W-1:0]  sel_ch,
    input  logic             sel_dir,
    input  logic             hold_we,
    input  logic [CFG_W-1:0] hold_wdata,
    input  logic             host_gnt,
    input  logic [CFG_W-1:0] ram_rdata,
    output logic             host_req,
    output logic             host_we,
    output logic [CH_W-1:0]  host_addr,
    output logic [CFG_W-1:0] host_wdata,
    output logic             busy,
    output logic             dir_q,
    output logic [CH_W-1:0]  ch_q,
    output logic [CFG_W-1:0] hold_q
);
    ind_state_t state_q, state_d;
    logic       accept_cmd;
    logic       accept_hold;

    assign accept_cmd  = (state_q == ST_IDLE) && sel_we;
    assign accept_hold = (state_q == ST_IDLE) && hold_we;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_we) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (host_gnt) state_d = dir_q ? ST_FETCH : ST_IDLE;
            end
            ST_FETCH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        host_req   = 1'b0;
        host_we    = 1'b0;
        busy       = 1'b1;
        host_addr  = ch_q;
        host_wdata = hold_q;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_WAIT: begin
                host_req = 1'b1;
                host_we  = !dir_q;
            end
            ST_FETCH: busy = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // command latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            dir_q <= 1'b0;
        end else if (accept_cmd) begin
            ch_q  <= sel_ch;
            dir_q <= sel_dir;
        end
    end

    // holding register: host when idle, memory at the end of a fetch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (state_q == ST_FETCH) begin
            hold_q <= ram_rdata;
        end else if (accept_hold) begin
            hold_q <= hold_wdata;
        end
    end
endmodule

// File: rtl/cfg_ind_access.sv
module cfg_ind_access
    import cfg_ind_pkg::*;
#(
    parameter int CH_W  = 8,
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             hold_we,
    input  logic [CFG_W-1:0] hold_wdata,
    input  logic             dp_req,
    input  logic             dp_we,
    input  logic [CH_W-1:0]  dp_addr,
    input  logic [CFG_W-1:0] dp_wdata,
    output logic [SEL_W-1:0] sel_rd,
    output logic [CFG_W-1:0] hold_rd,
    output logic [CFG_W-1:0] dp_rdata
);
    logic             host_req, host_we, host_gnt, busy, dir_q;
    logic [CH_W-1:0]  host_addr, ch_q, ram_addr;
    logic [CFG_W-1:0] host_wdata, ram_wdata, ram_rdata;
    logic             ram_en, ram_we;
    logic             unused_sel_bits;

    assign unused_sel_bits = ^{sel_wdata[SEL_BUSY_BIT], sel_wdata[SEL_DIR_BIT-1:CH_W]};

    cfg_ind_ctrl #(.CH_W(CH_W), .CFG_W(CFG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_ch     (sel_wdata[CH_W-1:0]),
        .sel_dir    (sel_wdata[SEL_DIR_BIT]),
        .hold_we    (hold_we),
        .hold_wdata (hold_wdata),
        .host_gnt   (host_gnt),
        .ram_rdata  (ram_rdata),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .busy       (busy),
        .dir_q      (dir_q),
        .ch_q       (ch_q),
        .hold_q     (hold_rd)
    );

    cfg_ind_arb #(.ADDR_W(CH_W), .DATA_W(CFG_W)) u_arb (
        .dp_req     (dp_req),
        .dp_we      (dp_we),
        .dp_addr    (dp_addr),
        .dp_wdata   (dp_wdata),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_gnt   (host_gnt),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata)
    );

    cfg_ind_ram #(.ADDR_W(CH_W), .DATA_W(CFG_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    assign dp_rdata = ram_rdata;

    // command readback: unused bits stay zero
    always_comb begin
        sel_rd               = '0;
        sel_rd[CH_W-1:0]     = ch_q;
        sel_rd[SEL_DIR_BIT]  = dir_q;
        sel_rd[SEL_BUSY_BIT] = busy;
    end
endmodule

// File: rtl/cfg_ind_chk.sv
module cfg_ind_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sel_we,
    input logic        dp_req,
    input logic [15:0] sel_rd,
    input logic [15:0] hold_rd
);
    assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rd[13:8] == 6'd0);

    assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_we && !sel_rd[15]) |=> sel_rd[15]);

    assert_dp_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rd[15] && !sel_rd[14] && dp_req) |=> sel_rd[15]);

    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_rd[15]) && sel_rd[15]) |-> $stable(hold_rd));

    assert_cmd_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_rd[15]) |-> $stable(sel_rd[14:0]));
endmodule

bind cfg_ind_access cfg_ind_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_we  (sel_we),
    .dp_req  (dp_req),
    .sel_rd  (sel_rd),
    .hold_rd (hold_rd)
);

// File: tb/tb_cfg_ind_access.sv
module tb_cfg_ind_access;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0;
    logic [15:0] sel_wdata = '0;
    logic        hold_we = 1'b0;
    logic [15:0] hold_wdata = '0;
    logic        dp_req = 1'b0;
    logic        dp_we = 1'b0;
    logic [7:0]  dp_addr = '0;
    logic [15:0] dp_wdata = '0;
    logic [15:0] sel_rd, hold_rd, dp_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cfg_ind_access dut (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .hold_we(hold_we), .hold_wdata(hold_wdata), .dp_req(dp_req),
        .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
        .sel_rd(sel_rd), .hold_rd(hold_rd), .dp_rdata(dp_rdata)
    );

    // behavioural reference
    logic [15:0] m_mem [256];
    int          m_phase = 0;
    logic [7:0]  m_ch = '0;
    logic        m_dir = 1'b0;
    logic [15:0] m_hold = '0;
    logic [15:0] m_fetch = '0;
    logic        m_dpv = 1'b0;
    logic [15:0] m_dpexp = '0;
    bit          m_known = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_ch = '0; m_dir = 1'b0; m_hold = '0; m_dpv = 1'b0;
        end else begin
            m_dpv = 1'b0;
            if (dp_req) begin
                if (dp_we) m_mem[dp_addr] = dp_wdata;
                else begin m_dpexp = m_mem[dp_addr]; m_dpv = 1'b1; end
            end
            case (m_phase)
                0: begin
                    if (sel_we) begin m_ch = sel_wdata[7:0]; m_dir = sel_wdata[14]; m_phase = 1; end
                    if (hold_we) m_hold = hold_wdata;
                end
                1: if (!dp_req) begin
                    if (m_dir) begin m_fetch = m_mem[m_ch]; m_phase = 2; end
                    else begin m_mem[m_ch] = m_hold; m_phase = 0; end
                end
                default: begin m_hold = m_fetch; m_phase = 0; end
            endcase
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 busy", {15'd0, sel_rd[15]}, {15'd0, m_phase != 0});
            check("R1 layout", {1'b0, sel_rd[14:0]}, {1'b0, m_dir, 6'd0, m_ch});
            check("R4 hold", hold_rd, m_hold);
            if (m_dpv && m_known) check("R8 dp read", dp_rdata, m_dpexp);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic start_cmd(input logic [7:0] ch, input logic rd);
        sel_we = 1'b1; sel_wdata = {1'b0, rd, 6'd0, ch};
        step();
        sel_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && sel_rd[15]; i++) step();
    endtask

    task automatic dp_read(input logic [7:0] a, output logic [15:0] v);
        dp_req = 1'b1; dp_we = 1'b0; dp_addr = a;
        step();
        dp_req = 1'b0;
        v = dp_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        step(); step();
        rst_n = 1'b1;
        step();
        // R2: reset values
        check("R2 sel", sel_rd, 16'h0000);
        check("R2 hold", hold_rd, 16'h0000);

        // preload every entry through the datapath (R8 store)
        for (int i = 0; i < 256; i++) begin
            dp_req = 1'b1; dp_we = 1'b1; dp_addr = 8'(i); dp_wdata = 16'(i * 97 + 16'h1234);
            step();
        end
        dp_req = 1'b0; dp_we = 1'b0;
        m_known = 1'b1;

        // R5: store holding to entry 00h and FFh (R9), holding written in same cycle as command
        hold_we = 1'b1; hold_wdata = 16'hA5A5;
        start_cmd(8'h00, 1'b0);
        hold_we = 1'b0;
        check("R3 busy after start", {15'd0, sel_rd[15]}, 16'd1);
        step();
        check("R5 write busy one cycle", {15'd0, sel_rd[15]}, 16'd0);
        hold_we = 1'b1; hold_wdata = 16'h5A5A; step(); hold_we = 1'b0;
        start_cmd(8'hFF, 1'b0);
        wait_idle();
        dp_read(8'h00, v); check("R5 R9 entry 00h", v, 16'hA5A5);
        dp_read(8'hFF, v); check("R5 R9 entry FFh", v, 16'h5A5A);

        // R4: read back entry 00h, busy two cycles
        start_cmd(8'h00, 1'b1);
        step();
        check("R4 busy mid fetch", {15'd0, sel_rd[15]}, 16'd1);
        step();
        check("R4 busy clear", {15'd0, sel_rd[15]}, 16'd0);
        check("R4 fetched word", hold_rd, 16'hA5A5);

        // R6: datapath holds memory for several cycles
        dp_req = 1'b1; dp_we = 1'b0; dp_addr = 8'd3;
        start_cmd(8'h09, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R6 held off", {15'd0, sel_rd[15]}, 16'd1);
        end
        dp_req = 1'b0;
        wait_idle();
        check("R6 fetched after release", hold_rd, m_mem[9]);

        // R7: writes while busy are ignored
        dp_req = 1'b1; dp_we = 1'b0; dp_addr = 8'd4;
        hold_we = 1'b1; hold_wdata = 16'h0F0F; step(); hold_we = 1'b0;
        start_cmd(8'h20, 1'b0);
        sel_we = 1'b1; sel_wdata = {2'b01, 6'd0, 8'h21};
        hold_we = 1'b1; hold_wdata = 16'hDEAD;
        step();
        sel_we = 1'b0; hold_we = 1'b0; dp_req = 1'b0;
        check("R7 channel kept", sel_rd[7:0], 16'h0020);
        check("R7 hold kept", hold_rd, 16'h0F0F);
        wait_idle();
        dp_read(8'h20, v); check("R7 stored original", v, 16'h0F0F);
        dp_read(8'h21, v); check("R7 other entry untouched", v, m_mem[8'h21]);

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            dp_req = ($urandom % 3) == 0;
            dp_we = $urandom % 2;
            dp_addr = 8'($urandom);
            dp_wdata = 16'($urandom);
            sel_we = ($urandom % 4) == 0;
            sel_wdata = {1'b0, 1'($urandom), 6'($urandom), 8'($urandom)};
            hold_we = ($urandom % 3) == 0;
            hold_wdata = 16'($urandom);
            step();
        end
        sel_we = 1'b0; hold_we = 1'b0; dp_req = 1'b0;
        wait_idle();
        step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule